// File: doc/BRIEF.md
# Write-Update Write-Through Snooping Cache Controller

This block is the coherence controller of one cache in a small shared-bus multiprocessor. It keeps a direct-mapped array of lines, each holding one data word, a tag and a coherence state. Three states describe a valid line. Exclusive-clean means this is the only copy and it matches memory. Shared means several copies exist and all match memory. Dirty means this is the only copy, it has been modified, and this cache owns it. A separate invalid code marks an empty line.

A processor issues single-word reads and writes and receives a completion pulse with a hit flag and read data. Misses, write-backs and update broadcasts go out on the snooping bus as one-word transactions. At the same time the controller watches the other caches' transactions. When it holds the addressed block it drives the wired shared line, supplies its copy, and takes in any new data. When a write lands on a shared block, the new word goes to memory and to every sharer in one update transaction. The shared line seen at the end of that transaction decides whether the line stays Shared or becomes exclusive-clean.

Top module: `wus_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid: no snooped transaction asserts `sharedOut`, and no bus or completion activity appears until a request arrives.
- R2: A read hit completes with `cpuHit`=1, returns the stored word, issues no bus transaction and leaves the line state unchanged.
- R3: A read miss with `sharedIn` low at acknowledge fetches the word from `busInData`, completes with `cpuHit`=0, and leaves the line exclusive-clean: a later write hit to it issues no bus transaction.
- R4: A read miss with `sharedIn` high at acknowledge takes the word supplied on `busInData` and leaves the line Shared: a later write hit to it issues an update.
- R5: A write hit to an exclusive-clean or Dirty line is done locally with no bus transaction and leaves the line Dirty.
- R6: A write hit to a Shared line issues one update transaction carrying the address and the new word. The line stays Shared if `sharedIn` is high at acknowledge, and becomes exclusive-clean otherwise.
- R7: A write miss issues one write-miss transaction carrying the new word. The line becomes Shared if `sharedIn` is high at acknowledge, and Dirty otherwise.
- R8: A miss whose index holds a Dirty line of another tag first issues a write-back of that line's address and word, then the miss transaction. A clean or Shared victim is dropped with no write-back.
- R9: `sharedOut` goes high in the same cycle as a snooped read-miss, write-miss or update only when the addressed line is valid with a matching tag. It stays low for a write-back or a non-matching line.
- R10: A snooped read-miss that hits drives the line's word on `supplyData`. It raises `supplyDirty` when the line was Dirty, and the line becomes Shared.
- R11: A snooped write-miss or update that hits replaces the line's word with `snpData` and makes the line Shared, without raising `supplyDirty`.
- R12: Each bus transaction holds `busValid`, `busCmd`, `busAddr` and `busData` steady until the cycle `busAck` is high, and `cpuDone` is a one-cycle pulse. Bus command codes: 0 read-miss, 1 write-miss, 2 update, 3 write-back. The line index is the low `IW` address bits and the tag is the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, accepted when the controller is idle |
| cpuWr | input | 1 | 1 for a write, 0 for a read |
| cpuAddr | input | AW | Request word address |
| cpuWdata | input | DW | Write data |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | Request hit in the cache, valid with `cpuDone` |
| cpuRdata | output | DW | Read data, valid with `cpuDone` |
| busValid | output | 1 | Outgoing bus transaction pending |
| busCmd | output | 2 | Transaction code (0 read-miss, 1 write-miss, 2 update, 3 write-back) |
| busAddr | output | AW | Transaction address |
| busData | output | DW | Write-miss, update or write-back data |
| busAck | input | 1 | Transaction completes in this cycle |
| busInData | input | DW | Word returned for a read-miss |
| sharedIn | input | 1 | Wired shared line, sampled when `busAck` is high |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 2 | Snooped transaction code |
| snpAddr | input | AW | Snooped address |
| snpData | input | DW | Snooped write data |
| sharedOut | output | 1 | This cache holds the snooped block |
| supplyDirty | output | 1 | Supplied word was Dirty; memory must capture it |
| supplyData | output | DW | This cache's copy of the snooped block |

## Verification
The bench steers each line through every state and proves the state through the bus traffic that follows. A write hit that goes out as an update, or silently does not, shows whether the line was Shared, and a snooped read-miss that raises the dirty-supply flag shows ownership. A design that ignored the shared line on an update would keep broadcasting after the last sharer left. One that wrote back clean victims would show an extra write-back before the miss, and one that dropped a Dirty victim would later read stale memory on the refetch. Snoops to empty lines, to a different tag on the same index and with the write-back code check that `sharedOut` is not asserted falsely. A delayed acknowledge checks that a request is held steady on the bus.

// File: rtl/wus_pkg.sv
package wus_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VEX = 2'd1,
    LS_SHR = 2'd2,
    LS_DRT = 2'd3
  } lineState_e;

  typedef enum logic [1:0] {
    BC_RDMISS = 2'd0,
    BC_WRMISS = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WBACK  = 2'd3
  } busCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capReq;      // latch processor request
    logic       fillWr;      // write the requested line
    logic       fillCpuData; // fill with processor data (else bus data)
    lineState_e fillState;   // state written with the fill
    logic       rspCap;      // capture response word
    logic       rspFromBus;  // response word comes from the bus
    logic       selVictim;   // bus address/data from the resident line
    logic       snpWr;       // snooped line moves to Shared
    logic       snpTakeData; // snooped line takes the bus word
  } ctrlStb_t;

endpackage

// File: rtl/wus_datapath.sv
module wus_datapath
  import wus_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 2,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   cpuAddr,
  input  logic            cpuWr,
  input  logic [DW-1:0]   cpuWdata,
  input  ctrlStb_t        stb,
  input  logic [AW-1:0]   snpAddr,
  input  logic [DW-1:0]   snpData,
  input  logic [DW-1:0]   busInData,
  output logic            reqWr,
  output logic            reqHit,
  output lineState_e      lineSt,
  output logic            snpHit,
  output lineState_e      snpSt,
  output logic [AW-1:0]   busAddr,
  output logic [DW-1:0]   busData,
  output logic [DW-1:0]   rdata,
  output logic [DW-1:0]   supplyData
);

  localparam int NL = 1 << IW;
  localparam int TW = AW - IW;

  lineState_e        stArr [NL];
  logic [TW-1:0]     tagArr [NL];
  logic [DW-1:0]     datArr [NL];

  logic [AW-1:0]     reqAddr;
  logic [DW-1:0]     reqWdata;

  logic [IW-1:0]     rIdx;
  logic [TW-1:0]     rTag;
  logic [IW-1:0]     sIdx;
  logic [TW-1:0]     sTag;

  assign rIdx = reqAddr[IW-1:0];
  assign rTag = reqAddr[AW-1:IW];
  assign sIdx = snpAddr[IW-1:0];
  assign sTag = snpAddr[AW-1:IW];

  // request latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWr    <= 1'b0;
      reqWdata <= '0;
    end else if (stb.capReq) begin
      reqAddr  <= cpuAddr;
      reqWr    <= cpuWr;
      reqWdata <= cpuWdata;
    end
  end

  // lookups
  assign lineSt     = stArr[rIdx];
  assign reqHit     = (stArr[rIdx] != LS_INV) && (tagArr[rIdx] == rTag);
  assign snpSt      = stArr[sIdx];
  assign snpHit     = (stArr[sIdx] != LS_INV) && (tagArr[sIdx] == sTag);
  assign supplyData = datArr[sIdx];

  assign busAddr = stb.selVictim ? {tagArr[rIdx], rIdx} : reqAddr;
  assign busData = stb.selVictim ? datArr[rIdx] : reqWdata;

  // state array; fill wins over a snoop to the same index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NL; i++) stArr[i] <= LS_INV;
    end else begin
      if (stb.snpWr) stArr[sIdx] <= LS_SHR;
      if (stb.fillWr) stArr[rIdx] <= stb.fillState;
    end
  end

  // tag and data arrays
  always_ff @(posedge clk) begin
    if (stb.snpTakeData) datArr[sIdx] <= snpData;
    if (stb.fillWr) begin
      tagArr[rIdx] <= rTag;
      datArr[rIdx] <= stb.fillCpuData ? reqWdata : busInData;
    end
  end

  // response word
  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (stb.rspCap) rdata <= stb.rspFromBus ? busInData : datArr[rIdx];
  end

endmodule

// File: rtl/wus_control.sv
module wus_control
  import wus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        reqWr,
  input  logic        reqHit,
  input  lineState_e  lineSt,
  input  logic        busAck,
  input  logic        sharedIn,
  input  logic        snpValid,
  input  busCmd_e     snpCmd,
  input  logic        snpHit,
  input  lineState_e  snpSt,
  output ctrlStb_t    stb,
  output logic        busValid,
  output busCmd_e     busCmd,
  output logic        cpuDone,
  output logic        cpuHit,
  output logic        sharedOut,
  output logic        supplyDirty
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_MISS, S_UPD, S_DONE
  } fsm_e;

  fsm_e st, nxt;
  logic hitQ;
  logic snpAct;

  assign snpAct      = snpValid && snpHit && (snpCmd != BC_WBACK);
  assign sharedOut   = snpAct;
  assign supplyDirty = snpAct && (snpCmd == BC_RDMISS) && (snpSt == LS_DRT);

  assign busValid = (st == S_WB) || (st == S_MISS) || (st == S_UPD);
  assign cpuDone  = (st == S_DONE);
  assign cpuHit   = hitQ;

  always_comb begin
    case (st)
      S_WB:    busCmd = BC_WBACK;
      S_UPD:   busCmd = BC_UPDATE;
      default: busCmd = reqWr ? BC_WRMISS : BC_RDMISS;
    endcase
  end

  always_comb begin
    stb             = '0;
    nxt             = st;
    stb.snpWr       = snpAct;
    stb.snpTakeData = snpAct && (snpCmd != BC_RDMISS);
    case (st)
      S_IDLE: begin
        if (cpuReq) begin
          stb.capReq = 1'b1;
          nxt        = S_LOOK;
        end
      end
      S_LOOK: begin
        if (reqHit) begin
          if (!reqWr) begin
            stb.rspCap = 1'b1;
            nxt        = S_DONE;
          end else if (lineSt == LS_SHR) begin
            nxt = S_UPD;
          end else begin
            stb.fillWr      = 1'b1;
            stb.fillCpuData = 1'b1;
            stb.fillState   = LS_DRT;
            nxt             = S_DONE;
          end
        end else if (lineSt == LS_DRT) begin
          nxt = S_WB;
        end else begin
          nxt = S_MISS;
        end
      end
      S_WB: begin
        stb.selVictim = 1'b1;
        if (busAck) nxt = S_MISS;
      end
      S_MISS: begin
        if (busAck) begin
          stb.fillWr      = 1'b1;
          stb.fillCpuData = reqWr;
          if (sharedIn)   stb.fillState = LS_SHR;
          else if (reqWr) stb.fillState = LS_DRT;
          else            stb.fillState = LS_VEX;
          stb.rspCap      = !reqWr;
          stb.rspFromBus  = 1'b1;
          nxt             = S_DONE;
        end
      end
      S_UPD: begin
        if (busAck) begin
          stb.fillWr      = 1'b1;
          stb.fillCpuData = 1'b1;
          stb.fillState   = sharedIn ? LS_SHR : LS_VEX;
          nxt             = S_DONE;
        end
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= S_IDLE;
      hitQ <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_LOOK) hitQ <= reqHit;
    end
  end

endmodule

// File: rtl/wus_snoop_ctrl.sv
module wus_snoop_ctrl
  import wus_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWr,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuDone,
  output logic          cpuHit,
  output logic [DW-1:0] cpuRdata,
  output logic          busValid,
  output logic [1:0]    busCmd,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busData,
  input  logic          busAck,
  input  logic [DW-1:0] busInData,
  input  logic          sharedIn,
  input  logic          snpValid,
  input  logic [1:0]    snpCmd,
  input  logic [AW-1:0] snpAddr,
  input  logic [DW-1:0] snpData,
  output logic          sharedOut,
  output logic          supplyDirty,
  output logic [DW-1:0] supplyData
);

  ctrlStb_t   stb;
  logic       reqWr;
  logic       reqHit;
  lineState_e lineSt;
  logic       snpHit;
  lineState_e snpSt;
  busCmd_e    busCmdE;

  assign busCmd = busCmdE;

  wus_datapath #(.AW(AW), .IW(IW), .DW(DW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cpuAddr    (cpuAddr),
    .cpuWr      (cpuWr),
    .cpuWdata   (cpuWdata),
    .stb        (stb),
    .snpAddr    (snpAddr),
    .snpData    (snpData),
    .busInData  (busInData),
    .reqWr      (reqWr),
    .reqHit     (reqHit),
    .lineSt     (lineSt),
    .snpHit     (snpHit),
    .snpSt      (snpSt),
    .busAddr    (busAddr),
    .busData    (busData),
    .rdata      (cpuRdata),
    .supplyData (supplyData)
  );

  wus_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReq      (cpuReq),
    .reqWr       (reqWr),
    .reqHit      (reqHit),
    .lineSt      (lineSt),
    .busAck      (busAck),
    .sharedIn    (sharedIn),
    .snpValid    (snpValid),
    .snpCmd      (busCmd_e'(snpCmd)),
    .snpHit      (snpHit),
    .snpSt       (snpSt),
    .stb         (stb),
    .busValid    (busValid),
    .busCmd      (busCmdE),
    .cpuDone     (cpuDone),
    .cpuHit      (cpuHit),
    .sharedOut   (sharedOut),
    .supplyDirty (supplyDirty)
  );

endmodule

// File: rtl/wus_snoop_chk.sv
module wus_snoop_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuDone,
  input logic          busValid,
  input logic [1:0]    busCmd,
  input logic [AW-1:0] busAddr,
  input logic [DW-1:0] busData,
  input logic          busAck,
  input logic          snpValid,
  input logic [1:0]    snpCmd,
  input logic          sharedOut,
  input logic          supplyDirty
);

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busAck |=> busValid && $stable(busCmd) && $stable(busAddr) && $stable(busData));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  assert_done_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !busValid);

  assert_shared_needs_snoop_R9: assert property (@(posedge clk) disable iff (!rstN)
    sharedOut |-> snpValid && (snpCmd != 2'd3));

  assert_flush_on_rdmiss_R10: assert property (@(posedge clk) disable iff (!rstN)
    supplyDirty |-> sharedOut && (snpCmd == 2'd0));

  assert_wb_then_miss_R8: assert property (@(posedge clk) disable iff (!rstN)
    busValid && (busCmd == 2'd3) && busAck |=> busValid && (busCmd <= 2'd1));

endmodule

bind wus_snoop_ctrl wus_snoop_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/wus_snoop_ctrl_bench.sv
module wus_snoop_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, UP = 3'd2, WB = 3'd3, NO = 3'd7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuReq = 1'b0, cpuWr = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic          cpuDone, cpuHit;
  logic [DW-1:0] cpuRdata;
  logic          busValid;
  logic [1:0]    busCmd;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busData;
  logic          busAck = 1'b0;
  logic [DW-1:0] busInData = '0;
  logic          sharedIn = 1'b0;
  logic          snpValid = 1'b0;
  logic [1:0]    snpCmd = '0;
  logic [AW-1:0] snpAddr = '0;
  logic [DW-1:0] snpData = '0;
  logic          sharedOut, supplyDirty;
  logic [DW-1:0] supplyData;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] mem [256];

  always #4 clk = ~clk;

  wus_snoop_ctrl u_wus_snoop_ctrl (.*);

  typedef struct packed {
    logic [1:0]  kind;    // 0 read, 1 write, 2 snoop
    logic [1:0]  scmd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        shr;
    logic        expHit;
    logic [31:0] expData;
    logic [2:0]  exp1;
    logic [2:0]  exp2;
    logic        expSh;
    logic        expFl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd0,2'd0,8'h10,32'h0,       1'b0,1'b0,32'hA0000010,RD,NO,1'b0,1'b0,4'd3},  // R3 read miss
    '{2'd0,2'd0,8'h10,32'h0,       1'b0,1'b1,32'hA0000010,NO,NO,1'b0,1'b0,4'd2},  // R2 read hit
    '{2'd1,2'd0,8'h10,32'h11111111,1'b0,1'b1,32'h0,       NO,NO,1'b0,1'b0,4'd5},  // R5 write hit excl
    '{2'd2,2'd0,8'h10,32'h0,       1'b0,1'b0,32'h11111111,NO,NO,1'b1,1'b1,4'd10}, // R10 dirty supply
    '{2'd2,2'd0,8'h10,32'h0,       1'b0,1'b0,32'h11111111,NO,NO,1'b1,1'b0,4'd10}, // R10 now shared
    '{2'd1,2'd0,8'h10,32'h22222222,1'b1,1'b1,32'h0,       UP,NO,1'b0,1'b0,4'd6},  // R6 update, stays shared
    '{2'd1,2'd0,8'h10,32'h33333333,1'b0,1'b1,32'h0,       UP,NO,1'b0,1'b0,4'd6},  // R6 update, last sharer gone
    '{2'd1,2'd0,8'h10,32'h44444444,1'b0,1'b1,32'h0,       NO,NO,1'b0,1'b0,4'd6},  // R6 now exclusive
    '{2'd0,2'd0,8'h14,32'h0,       1'b0,1'b0,32'hA0000014,WB,RD,1'b0,1'b0,4'd8},  // R8 dirty victim
    '{2'd0,2'd0,8'h10,32'h0,       1'b0,1'b0,32'h44444444,RD,NO,1'b0,1'b0,4'd8},  // R8 clean victim
    '{2'd1,2'd0,8'h21,32'h55555555,1'b0,1'b0,32'h0,       WR,NO,1'b0,1'b0,4'd7},  // R7 miss from memory
    '{2'd1,2'd0,8'h21,32'h66666666,1'b0,1'b1,32'h0,       NO,NO,1'b0,1'b0,4'd7},  // R7 dirty
    '{2'd1,2'd0,8'h22,32'h77777777,1'b1,1'b0,32'h0,       WR,NO,1'b0,1'b0,4'd7},  // R7 miss shared
    '{2'd1,2'd0,8'h22,32'h88888888,1'b1,1'b1,32'h0,       UP,NO,1'b0,1'b0,4'd7},  // R7 shared
    '{2'd2,2'd2,8'h22,32'h99999999,1'b0,1'b0,32'h0,       NO,NO,1'b1,1'b0,4'd11}, // R11 snoop update
    '{2'd0,2'd0,8'h22,32'h0,       1'b0,1'b1,32'h99999999,NO,NO,1'b0,1'b0,4'd11}, // R11 new word
    '{2'd2,2'd0,8'h33,32'h0,       1'b0,1'b0,32'h0,       NO,NO,1'b0,1'b0,4'd9},  // R9 empty line
    '{2'd2,2'd0,8'h26,32'h0,       1'b0,1'b0,32'h0,       NO,NO,1'b0,1'b0,4'd9},  // R9 other tag
    '{2'd2,2'd3,8'h22,32'h0,       1'b0,1'b0,32'h0,       NO,NO,1'b0,1'b0,4'd9},  // R9 write-back code
    '{2'd2,2'd1,8'h21,32'hABABABAB,1'b0,1'b0,32'h0,       NO,NO,1'b1,1'b0,4'd11}, // R11 snoop write miss
    '{2'd1,2'd0,8'h21,32'hCDCDCDCD,1'b1,1'b1,32'h0,       UP,NO,1'b0,1'b0,4'd11}, // R11 now shared
    '{2'd0,2'd0,8'h23,32'hEEEEEEEE,1'b1,1'b0,32'hEEEEEEEE,RD,NO,1'b0,1'b0,4'd4},  // R4 supplied by cache
    '{2'd1,2'd0,8'h23,32'hF0F0F0F0,1'b1,1'b1,32'h0,       UP,NO,1'b0,1'b0,4'd4},  // R4 shared
    '{2'd0,2'd0,8'h21,32'h0,       1'b0,1'b1,32'hCDCDCDCD,NO,NO,1'b0,1'b0,4'd11}  // R11 read back
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one processor access with the bus modelled; every acked cycle is one transaction
  task automatic cpuOp(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input bit shr, input logic [31:0] sup, input int holdOff,
                       output bit hit, output logic [31:0] rd,
                       output logic [2:0] c1, output logic [2:0] c2);
    int n = 0;
    int wait4 = holdOff;
    c1 = NO; c2 = NO;
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = wr; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuReq = 1'b0;
    for (int g = 0; g < 64; g++) begin
      busAck = 1'b0;
      if (cpuDone) break;
      if (busValid) begin
        if (wait4 > 0) begin
          check(busCmd == 2'd0 && busAddr == a, 12, "request held without ack",
                {22'd0, busCmd, busAddr}, {22'd0, 2'd0, a});
          wait4--;
        end else begin
          if (n == 0) c1 = {1'b0, busCmd}; else c2 = {1'b0, busCmd};
          n++;
          busAck = 1'b1;
          sharedIn = shr;
          case (busCmd)
            2'd0: busInData = shr ? sup : mem[busAddr];
            2'd1: if (shr) mem[busAddr] = busData;
            default: mem[busAddr] = busData;
          endcase
        end
      end
      @(negedge clk);
    end
    hit = cpuHit;
    rd  = cpuRdata;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic [31:0] d,
                       output bit sh, output bit fl, output logic [31:0] sd);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = c; snpAddr = a; snpData = d;
    #1;
    sh = sharedOut; fl = supplyDirty; sd = supplyData;
    if (fl) mem[a] = sd;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    bit hit, sh, fl;
    logic [31:0] rd, sd;
    logic [2:0] c1, c2;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA0000000 | i;

    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and just after
    check(!cpuDone && !busValid, 1, "quiet during reset", {30'd0, cpuDone, busValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!cpuDone && !busValid && !sharedOut, 1, "quiet after reset",
          {29'd0, cpuDone, busValid, sharedOut}, 0);
    for (int k = 0; k < 4; k++) begin
      snoop(2'd0, 8'h10 + 8'(k), 32'h0, sh, fl, sd);
      check(!sh, 1, "no line valid after reset", {31'd0, sh}, 0);
    end

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].kind != 2'd2) begin
        cpuOp(VECS[v].kind[0], VECS[v].addr, VECS[v].data, VECS[v].shr, VECS[v].data, 0,
              hit, rd, c1, c2);
        check(hit == VECS[v].expHit, VECS[v].req, $sformatf("vec %0d hit", v),
              {31'd0, hit}, {31'd0, VECS[v].expHit});
        if (VECS[v].kind == 2'd0)
          check(rd == VECS[v].expData, VECS[v].req, $sformatf("vec %0d read data", v),
                rd, VECS[v].expData);
        check(c1 == VECS[v].exp1 && c2 == VECS[v].exp2, VECS[v].req,
              $sformatf("vec %0d bus commands", v), {26'd0, c1, c2},
              {26'd0, VECS[v].exp1, VECS[v].exp2});
      end else begin
        snoop(VECS[v].scmd, VECS[v].addr, VECS[v].data, sh, fl, sd);
        check(sh == VECS[v].expSh, VECS[v].req, $sformatf("vec %0d shared", v),
              {31'd0, sh}, {31'd0, VECS[v].expSh});
        check(fl == VECS[v].expFl, VECS[v].req, $sformatf("vec %0d dirty supply", v),
              {31'd0, fl}, {31'd0, VECS[v].expFl});
        if (VECS[v].expSh && VECS[v].scmd == 2'd0)
          check(sd == VECS[v].expData, VECS[v].req, $sformatf("vec %0d supply data", v),
                sd, VECS[v].expData);
      end
    end

    // R12: acknowledge withheld three cycles on a read miss, then one-cycle done pulse
    cpuOp(1'b0, 8'h31, 32'h0, 1'b0, 32'h0, 3, hit, rd, c1, c2);
    check(!hit && rd == 32'hA0000031, 12, "delayed ack read data", rd, 32'hA0000031);
    check(c1 == RD && c2 == NO, 12, "delayed ack commands", {26'd0, c1, c2}, {26'd0, RD, NO});
    @(negedge clk);
    check(!cpuDone, 12, "done is one cycle", {31'd0, cpuDone}, 0);

    finishRun();
  end

endmodule